// File: doc/BRIEF.md
# Programmable power-of-two clock divider

The block divides a count clock by a power of two chosen at run time. A binary counter, modelled synchronously on a fast system clock, advances once for each rising edge seen on either of two asynchronous count-clock pins. The output `q_o` is the counter stage picked by a programming code N, so its frequency is the count-clock frequency divided by 2^N. Codes 0 and 1 select no stage and hold the output low. Three fixed test taps bring out counter stages that do not depend on the code.

The two count-clock pins gate each other. A rising edge on one pin advances the counter only while the other pin was low. If the other pin is high, the edge is blocked. A system can therefore feed its clock into one pin and use the other pin as a count enable, held low to count and high to stop. Both pins pass through two-flop synchronizers. The active-low clear takes effect at once when asserted and is released on the system clock.

Control is a three-state machine. `ST_CLEAR` is entered at once whenever the released clear is held low. On the first system clock after release, the machine moves to `ST_DIVIDE` when the code is 2 or more, and otherwise to `ST_INHIBIT`. After that it moves between `ST_INHIBIT` and `ST_DIVIDE` on each clock according to the current code. The output is high only in `ST_DIVIDE`, and only while the selected stage is high.

Top module: `pow2_divider`

## Requirements
- R1: With code N of 2 or more, `q_o` equals counter bit N-1. Its period is therefore 2^N counts: code 2 divides by 4, and code 9 divides by 512.
- R2: With code 0 or 1, `q_o` is held low whatever the count.
- R3: While `clr_n` is low, the counter is zero, and `q_o` and every bit of `tap_o` are low. This takes effect without waiting for a system clock edge.
- R4: A rising edge on `cnt_clk_a` while `cnt_clk_b` is low advances the counter by one.
- R5: A rising edge on `cnt_clk_b` while `cnt_clk_a` is low advances the counter by one.
- R6: A rising edge on one count pin while the other pin is high does not advance the counter.
- R7: Rising edges on both count pins in the same system-clock sample advance the counter by exactly one.
- R8: `tap_o[0]`, `tap_o[1]` and `tap_o[2]` are counter bits 0, 3 and 8. They divide by 2, 16 and 512, and they do not depend on the code.
- R9: A new code value takes effect on the next system clock edge and leaves the counter unchanged.
- R10: After `clr_n` rises, the block ignores count-pin activity for the first two system clock edges. A pin pulse that is high only at the first of those edges is never counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than either count clock |
| clr_n | input | 1 | Active-low clear, asserted asynchronously and released synchronously |
| cnt_clk_a | input | 1 | First count-clock pin (asynchronous) |
| cnt_clk_b | input | 1 | Second count-clock pin (asynchronous) |
| code_i | input | CODE_W | Division code N; the output divides by 2^N |
| q_o | output | 1 | Divided output |
| tap_o | output | 3 | Fixed test taps: counter bits 0, 3 and 8 |

## Verification
The bench builds the block with CODE_W = 4, which gives a 15-bit counter. With that setting the code range is exercised end to end, and the inhibit codes and every division code sit alongside a counter short enough to follow closely. Taps keep their defaults of 0, 3 and 8. A few hundred count pulses are enough to carry the divide-by-512 tap and code 9 through a transition. The mutual-inhibit, simultaneous-edge and clear-release cases are driven with pin timing chosen around the synchronizer delay.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;

    // Control states of the divider
    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_INHIBIT = 2'd1,
        ST_DIVIDE  = 2'd2
    } div_state_e;

    // Lowest code that selects a counter stage
    localparam int MIN_DIV_CODE = 2;

    function automatic div_state_e mode_for_code(input int code);
        return (code >= MIN_DIV_CODE) ? ST_DIVIDE : ST_INHIBIT;
    endfunction

endpackage

// File: rtl/pow2_div_sync.sv
// Multi-stage level synchronizer with asynchronous clear to zero.
// With d tied high and rst_n on the raw clear, it releases a reset synchronously.
module pow2_div_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pow2_div_gate.sv
// Edge detection of the two synchronized count pins with mutual inhibit.
module pow2_div_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_a,
    input  logic lvl_b,
    output logic inc
);
    logic prev_a;
    logic prev_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= lvl_a;
            prev_b <= lvl_b;
        end
    end

    // A rise on one pin counts only if the other was low; both rising count once.
    always_comb begin
        inc = 1'b0;
        if (!prev_a && !prev_b && (lvl_a || lvl_b)) inc = 1'b1;
    end

    // R4 R5 R6: a count always follows a rise of a pin whose partner was low
    p_gate_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (($rose(lvl_a) && !$past(lvl_b)) || ($rose(lvl_b) && !$past(lvl_a))));

    // R7: one pulse per edge event, never two in a row
    p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> !inc);
endmodule

// File: rtl/pow2_div_counter.sv
// Binary count register advanced by the gated increment pulse.
module pow2_div_counter #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R3: counter is zero whenever the internal clear is active
    p_clear_zero_r3: assert property (@(posedge clk)
        !rst_n |-> (cnt == '0));

    // R4: each pulse from the gate moves the count by exactly one
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + 1'b1));

    // R6: without a pulse the count holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/pow2_div_ctrl.sv
// Clear release, code register, mode state machine and output stage select.
module pow2_div_ctrl
    import pow2_div_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RST_STAGES = 2,
    localparam int CNT_W     = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              clr_n_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  cnt,
    output logic              rst_n_o,
    output logic              q_o
);
    div_state_e        state;
    div_state_e        state_nxt;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] sel_idx;

    // Clear asserts at once and releases after RST_STAGES clocks
    pow2_div_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk   (clk),
        .rst_n (clr_n_i),
        .d     (1'b1),
        .q     (rst_n_o)
    );

    always_ff @(posedge clk or negedge rst_n_o) begin
        if (!rst_n_o) code_q <= '0;
        else          code_q <= code_i;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n_o) begin
        if (!rst_n_o) state <= ST_CLEAR;
        else          state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLEAR:   state_nxt = mode_for_code(int'(code_i));
            ST_INHIBIT: state_nxt = mode_for_code(int'(code_i));
            ST_DIVIDE:  state_nxt = mode_for_code(int'(code_i));
            default:    state_nxt = ST_CLEAR;
        endcase
    end

    assign sel_idx = code_q - {{(CODE_W-1){1'b0}}, 1'b1};

    // Output logic
    always_comb begin
        q_o = 1'b0;
        unique case (state)
            ST_CLEAR:   q_o = 1'b0;
            ST_INHIBIT: q_o = 1'b0;
            ST_DIVIDE:  q_o = cnt[sel_idx];
            default:    q_o = 1'b0;
        endcase
    end

    // R2: inhibit codes keep the output low
    p_inhibit_low_r2: assert property (@(posedge clk) disable iff (!rst_n_o)
        (int'(code_q) < MIN_DIV_CODE) |-> !q_o);

    // R9: divide mode always agrees with the registered code
    p_state_code_r9: assert property (@(posedge clk) disable iff (!rst_n_o)
        (state == ST_DIVIDE) |-> (int'(code_q) >= MIN_DIV_CODE));

    // R10: internal release only after the clear pin was already high
    p_release_r10: assert property (@(posedge clk) disable iff (!clr_n_i)
        $rose(rst_n_o) |-> $past(clr_n_i));
endmodule

// File: rtl/pow2_divider.sv
// Programmable power-of-two divider top level.
module pow2_divider #(
    parameter int CODE_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int TAP0        = 0,
    parameter int TAP1        = 3,
    parameter int TAP2        = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              cnt_clk_a,
    input  logic              cnt_clk_b,
    input  logic [CODE_W-1:0] code_i,
    output logic              q_o,
    output logic [2:0]        tap_o
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic             rst_n_int;
    logic [1:0]       pin_raw;
    logic [1:0]       pin_lvl;
    logic             inc;
    logic [CNT_W-1:0] cnt;

    assign pin_raw = {cnt_clk_b, cnt_clk_a};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_pin_sync
            pow2_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n_int),
                .d     (pin_raw[i]),
                .q     (pin_lvl[i])
            );
        end
    endgenerate

    pow2_div_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n_int),
        .lvl_a (pin_lvl[0]),
        .lvl_b (pin_lvl[1]),
        .inc   (inc)
    );

    pow2_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n_int),
        .inc   (inc),
        .cnt   (cnt)
    );

    pow2_div_ctrl #(.CODE_W(CODE_W), .RST_STAGES(2)) u_ctrl (
        .clk     (clk),
        .clr_n_i (clr_n),
        .code_i  (code_i),
        .cnt     (cnt),
        .rst_n_o (rst_n_int),
        .q_o     (q_o)
    );

    // R8: fixed taps, independent of the code
    assign tap_o = {cnt[TAP2], cnt[TAP1], cnt[TAP0]};
endmodule

// File: tb/pow2_divider_tb.sv
module pow2_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 4;
    localparam int CNT_W      = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              clr_n = 1'b0;
    logic              pin_a = 1'b0;
    logic              pin_b = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic              q;
    logic [2:0]        tap;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase  = "R3";
    bit    done   = 1'b0;

    // Behavioural reference state
    int rel;
    int a0, a1, ap, b0, b1, bp;
    int mcount;
    int mcode;

    pow2_divider #(.CODE_W(CODE_W)) u_dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .cnt_clk_a (pin_a),
        .cnt_clk_b (pin_b),
        .code_i    (code),
        .q_o       (q),
        .tap_o     (tap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            rel = 0; a0 = 0; a1 = 0; ap = 0; b0 = 0; b1 = 0; bp = 0;
            mcount = 0; mcode = 0;
        end else if (rel < 2) begin
            rel = rel + 1;
        end else begin
            if (ap == 0 && bp == 0 && (a1 == 1 || b1 == 1))
                mcount = (mcount + 1) % (1 << CNT_W);
            ap = a1; a1 = a0; a0 = int'(pin_a);
            bp = b1; b1 = b0; b0 = int'(pin_b);
            mcode = int'(code);
        end
    end

    function automatic int exp_q();
        if (mcode < 2) return 0;
        return (mcount >> (mcode - 1)) & 1;
    endfunction

    function automatic int exp_tap();
        return (((mcount >> 8) & 1) << 2) | (((mcount >> 3) & 1) << 1) | (mcount & 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference every cycle
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk({phase, " q"}, int'(q), exp_q());
            chk({phase, " tap"}, int'(tap), exp_tap());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pin_a = 1'b1;
            wait_cyc(3);
            pin_a = 1'b0;
            wait_cyc(3);
        end
    endtask

    task automatic pulse_b(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pin_b = 1'b1;
            wait_cyc(3);
            pin_b = 1'b0;
            wait_cyc(3);
        end
    endtask

    task automatic set_code(input int v);
        @(negedge clk) code = CODE_W'(v);
        @(negedge clk);
        #2;
    endtask

    initial begin
        // R3: reset state
        wait_cyc(3);
        #2;
        chk("R3 reset q", int'(q), 0);
        chk("R3 reset tap", int'(tap), 0);
        @(negedge clk) clr_n = 1'b1;
        wait_cyc(4);

        // R1 R4: code 2, six counts on pin a -> count 6, bit1 high
        phase = "R4";
        set_code(2);
        pulse_a(6);
        wait_cyc(4);
        #2;
        chk("R1 code2 q", int'(q), 1);
        chk("R4 count6 tap", int'(tap), 0);

        // R2: inhibit codes
        phase = "R2";
        set_code(1);
        chk("R2 code1 q", int'(q), 0);
        set_code(0);
        chk("R2 code0 q", int'(q), 0);

        // R9: new code applies on next edge, counter kept
        phase = "R9";
        @(negedge clk) code = CODE_W'(3);
        #2;
        chk("R9 before edge q", int'(q), 0);
        @(negedge clk);
        #2;
        chk("R9 after edge q", int'(q), 1);

        // R5: counts on pin b -> 8
        phase = "R5";
        pulse_b(2);
        wait_cyc(4);
        set_code(4);
        chk("R5 count8 q", int'(q), 1);
        chk("R5 count8 tap", int'(tap), 2);

        // R6: pin b raised (counts once -> 9), then pin a pulses blocked
        phase = "R6";
        @(negedge clk) pin_b = 1'b1;
        wait_cyc(6);
        pulse_a(3);
        @(negedge clk) pin_b = 1'b0;
        wait_cyc(6);
        #2;
        chk("R6 blocked tap", int'(tap), 3);
        chk("R6 blocked q", int'(q), 1);

        // R7: both pins rise together -> 10
        phase = "R7";
        @(negedge clk) begin pin_a = 1'b1; pin_b = 1'b1; end
        wait_cyc(4);
        pin_a = 1'b0; pin_b = 1'b0;
        wait_cyc(5);
        #2;
        chk("R7 single count tap", int'(tap), 2);
        set_code(2);
        chk("R7 single count q", int'(q), 1);

        // R3: asynchronous clear mid-run
        phase = "R3";
        @(negedge clk) clr_n = 1'b0;
        #2;
        chk("R3 async q", int'(q), 0);
        chk("R3 async tap", int'(tap), 0);
        wait_cyc(2);

        // R10: short pulse during release is not counted
        phase = "R10";
        @(negedge clk) begin clr_n = 1'b1; pin_a = 1'b1; end
        @(negedge clk) pin_a = 1'b0;
        wait_cyc(6);
        #2;
        chk("R10 release tap", int'(tap), 0);
        @(negedge clk) pin_a = 1'b1;
        @(negedge clk) pin_a = 1'b0;
        wait_cyc(5);
        #2;
        chk("R10 later pulse tap", int'(tap), 1);

        // R8 R1: long run to the divide-by-512 stage -> 257
        phase = "R8";
        set_code(9);
        pulse_a(256);
        wait_cyc(4);
        #2;
        chk("R8 tap 257", int'(tap), 5);
        chk("R1 code9 q", int'(q), 1);
        set_code(0);
        chk("R8 tap code0", int'(tap), 5);
        chk("R2 code0 q late", int'(q), 0);

        wait_cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule